// File: doc/BRIEF.md
# Boot-Remap Address Decoder

This block turns each system bus request address into exactly one region select for the processor memory map. The map has eight external chip-select regions, four internal regions and one peripheral region. The lowest internal region, at address zero, is a window and not a memory of its own. While reset is low, a boot-mode pin is sampled. It decides whether the window shows the internal ROM (internal region 1) or the first external region. Later, a one-cycle remap command moves internal SRAM (internal region 2) into the window. The decoder also rewrites the outgoing physical address so that the selected memory sees its own base.

Every data access is checked for alignment. A misaligned data access, or an address that falls in no region, is refused with an abort pulse in place of a select. When an abort happens, the requesting master, the direction, the size, the address and the abort cause are captured in status outputs. These outputs hold their values until the next abort. All outputs appear one clock after the request.

Top module: `bus_remap_decoder`

## Requirements
- R1: An address whose top nibble is 1 to 8 selects external chip select `ext_cs[nibble-1]`, and `phys_addr` equals the request address.
- R2: An address with top nibble 0, bits 27:22 zero and bits 21:20 equal to 1, 2 or 3 selects `int_cs[bits 21:20]` (ROM is 1, SRAM is 2), with `phys_addr` equal to the request address. `int_cs[0]` is never asserted.
- R3: An address with top nibble 0xF selects `periph_cs`, with `phys_addr` equal to the request address.
- R4: `boot_mode_pin` is captured on every clock edge while `rst_n` is low and is held after reset. With the remap off, a window access (top nibble 0, bits 27:20 zero) goes to `int_cs[1]` with `phys_addr` = 0x0010_0000 + bits 19:0 when the captured value is 1. When the captured value is 0, it goes to `ext_cs[0]` with `phys_addr` = 0x1000_0000 + bits 19:0.
- R5: Each cycle with `remap_cmd` high toggles the remap state, and reset clears it. While the remap is on, a window access selects `int_cs[2]` with `phys_addr` = 0x0020_0000 + bits 19:0.
- R6: A request in the same cycle as `remap_cmd` is decoded with the mapping that held before that command.
- R7: A data access (`req_data`=1) with size code 1 (halfword) and address bit 0 set, or with size code 2 or 3 (word) and address bits 1:0 nonzero, aborts. A byte access (size code 0) never aborts for alignment, and instruction fetches (`req_data`=0) are never checked.
- R8: Top nibbles 9 to 0xE, and top nibble 0 with any of bits 27:22 set, are undefined and abort. When an access is both undefined and misaligned, the cause code is undefined.
- R9: An aborting request raises `abort_o` for one cycle with no select. The status outputs then take the master, the write flag, the size, the address and the cause code (1 = misaligned, 2 = undefined address). They hold these values until the next abort, and reset clears them to zero.
- R10: Selects, `sel_vld`, `phys_addr` and `abort_o` reflect the request of the previous cycle. After a cycle with no request, all of them are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode_pin | input | 1 | Boot source pin, captured while in reset |
| remap_cmd | input | 1 | One-cycle pulse toggling the remap state |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_write | input | 1 | 1 for a write |
| req_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| req_master | input | 2 | Requesting master number |
| sel_vld | output | 1 | A region select is active |
| ext_cs | output | 8 | External region selects |
| int_cs | output | 4 | Internal region selects |
| periph_cs | output | 1 | Peripheral region select |
| phys_addr | output | 32 | Address presented to the selected region |
| abort_o | output | 1 | Abort pulse for the previous request |
| abt_type | output | 2 | Captured cause: 1 misaligned, 2 undefined |
| abt_master | output | 2 | Captured master |
| abt_write | output | 1 | Captured write flag |
| abt_size | output | 2 | Captured size |
| abt_addr | output | 32 | Captured address |

## Verification
The critical overlap is a remap command arriving in the same cycle as a request to the window. The mapping must not change under that request. The stimulus places window accesses in the exact cycle of each toggle, both with directed pulses and with random pulses. The reference model decodes first and toggles after, and it flags any select or physical address taken from the new mapping. A second overlap is an address that is both undefined and misaligned. The stimulus aims such accesses at the gap regions, and the captured cause must read undefined.

// File: rtl/brd_pkg.sv
package brd_pkg;

  localparam int ADDR_W = 32;
  localparam int NIB_LSB = ADDR_W - 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ABT_NONE     = 2'd0,
    ABT_MISALIGN = 2'd1,
    ABT_UNDEF    = 2'd2
  } abt_type_e;

  // alignment rule: bytes never fault, halfwords need bit 0 clear,
  // words need both low bits clear
  function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] lo);
    logic bad;
    case (sz)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = lo[0];
      default: bad = |lo;
    endcase
    return bad;
  endfunction

  // top address nibble selects the coarse 256 MB slot
  function automatic logic [3:0] top_nibble(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:NIB_LSB];
  endfunction

endpackage

// File: rtl/brd_boot_map.sv
module brd_boot_map (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_mode_pin,
  input  logic remap_cmd,
  output logic boot_q,
  output logic remap_q
);

  // boot pin follows the pad during reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= boot_mode_pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         remap_q <= 1'b0;
    else if (remap_cmd) remap_q <= ~remap_q;
  end

endmodule

// File: rtl/brd_region_dec.sv
module brd_region_dec
  import brd_pkg::*;
#(
  parameter int N_EXT        = 8,
  parameter int N_INT        = 4,
  parameter int EXT_BASE_NIB = 1,
  parameter int PERIPH_NIB   = 15,
  parameter int AREA_OFF_W   = 20,
  parameter int ROM_AREA     = 1,
  parameter int SRAM_AREA    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_q,
  input  logic              remap_q,
  output logic [N_EXT-1:0]  ext_hit,
  output logic [N_INT-1:0]  int_hit,
  output logic              periph_hit,
  output logic              undef_hit,
  output logic [ADDR_W-1:0] phys
);

  localparam int IDX_W   = $clog2(N_INT);
  localparam int IDX_LSB = AREA_OFF_W;
  localparam int GAP_LSB = AREA_OFF_W + IDX_W;

  logic [3:0]            nib;
  logic                  in_int;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      tgt_idx;
  logic [IDX_W-1:0]      eff_idx;
  logic                  in_window;
  logic                  alias_ext;
  logic                  in_ext;
  logic [AREA_OFF_W-1:0] off;

  assign nib       = top_nibble(addr);
  assign in_int    = (nib == 4'd0) && ~|addr[NIB_LSB-1:GAP_LSB];
  assign idx       = addr[GAP_LSB-1:IDX_LSB];
  assign off       = addr[AREA_OFF_W-1:0];
  assign in_window = in_int && (idx == '0);
  assign alias_ext = in_window && !remap_q && !boot_q;
  assign tgt_idx   = remap_q ? IDX_W'(SRAM_AREA) : IDX_W'(ROM_AREA);
  assign eff_idx   = in_window ? tgt_idx : idx;
  assign in_ext    = ({1'b0, nib} >= 5'(EXT_BASE_NIB)) &&
                     ({1'b0, nib} <  5'(EXT_BASE_NIB + N_EXT));

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    if (g == 0) begin : g_first
      assign ext_hit[g] = (nib == 4'(EXT_BASE_NIB)) || alias_ext;
    end else begin : g_rest
      assign ext_hit[g] = (nib == 4'(EXT_BASE_NIB + g));
    end
  end

  for (genvar g = 0; g < N_INT; g++) begin : g_int
    assign int_hit[g] = in_int && !alias_ext && (eff_idx == IDX_W'(g));
  end

  assign periph_hit = (nib == 4'(PERIPH_NIB));
  assign undef_hit  = !(in_int || in_ext || periph_hit);

  always_comb begin
    phys = addr;
    if (alias_ext)
      phys = {4'(EXT_BASE_NIB), {(NIB_LSB-AREA_OFF_W){1'b0}}, off};
    else if (in_window)
      phys = {{(ADDR_W-GAP_LSB){1'b0}}, tgt_idx, off};
  end

endmodule

// File: rtl/brd_abort_capture.sv
module brd_abort_capture
  import brd_pkg::*;
#(
  parameter int MASTER_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [1:0]          cause,
  input  logic [MASTER_W-1:0] master,
  input  logic                write,
  input  logic [1:0]          size,
  input  logic [ADDR_W-1:0]   addr,
  output logic [1:0]          st_type,
  output logic [MASTER_W-1:0] st_master,
  output logic                st_write,
  output logic [1:0]          st_size,
  output logic [ADDR_W-1:0]   st_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_type   <= ABT_NONE;
      st_master <= '0;
      st_write  <= 1'b0;
      st_size   <= 2'd0;
      st_addr   <= '0;
    end else if (fire) begin
      st_type   <= cause;
      st_master <= master;
      st_write  <= write;
      st_size   <= size;
      st_addr   <= addr;
    end
  end

endmodule

// File: rtl/bus_remap_decoder.sv
module bus_remap_decoder
  import brd_pkg::*;
#(
  parameter int N_EXT        = 8,
  parameter int N_INT        = 4,
  parameter int MASTER_W     = 2,
  parameter int EXT_BASE_NIB = 1,
  parameter int PERIPH_NIB   = 15,
  parameter int AREA_OFF_W   = 20,
  parameter int ROM_AREA     = 1,
  parameter int SRAM_AREA    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_mode_pin,
  input  logic                remap_cmd,
  input  logic                req_vld,
  input  logic [31:0]         req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic                req_data,
  input  logic [MASTER_W-1:0] req_master,
  output logic                sel_vld,
  output logic [N_EXT-1:0]    ext_cs,
  output logic [N_INT-1:0]    int_cs,
  output logic                periph_cs,
  output logic [31:0]         phys_addr,
  output logic                abort_o,
  output logic [1:0]          abt_type,
  output logic [MASTER_W-1:0] abt_master,
  output logic                abt_write,
  output logic [1:0]          abt_size,
  output logic [31:0]         abt_addr
);

  // named internal events, visible to the bound checker
  logic              boot_q;
  logic              remap_q;
  logic [N_EXT-1:0]  dec_ext;
  logic [N_INT-1:0]  dec_int;
  logic              dec_periph;
  logic              dec_undef;
  logic [31:0]       dec_phys;
  logic              ev_misalign;
  logic              ev_undef;
  logic              ev_fire;
  logic              ev_pass;
  logic [1:0]        ev_cause;

  brd_boot_map u_boot (
    .clk           (clk),
    .rst_n         (rst_n),
    .boot_mode_pin (boot_mode_pin),
    .remap_cmd     (remap_cmd),
    .boot_q        (boot_q),
    .remap_q       (remap_q)
  );

  brd_region_dec #(
    .N_EXT        (N_EXT),
    .N_INT        (N_INT),
    .EXT_BASE_NIB (EXT_BASE_NIB),
    .PERIPH_NIB   (PERIPH_NIB),
    .AREA_OFF_W   (AREA_OFF_W),
    .ROM_AREA     (ROM_AREA),
    .SRAM_AREA    (SRAM_AREA)
  ) u_dec (
    .addr       (req_addr),
    .boot_q     (boot_q),
    .remap_q    (remap_q),
    .ext_hit    (dec_ext),
    .int_hit    (dec_int),
    .periph_hit (dec_periph),
    .undef_hit  (dec_undef),
    .phys       (dec_phys)
  );

  assign ev_misalign = req_vld && req_data && is_misaligned(req_size, req_addr[1:0]);
  assign ev_undef    = req_vld && dec_undef;
  assign ev_fire     = ev_misalign || ev_undef;
  assign ev_pass     = req_vld && !ev_fire;
  assign ev_cause    = ev_undef ? ABT_UNDEF : ABT_MISALIGN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_vld   <= 1'b0;
      ext_cs    <= '0;
      int_cs    <= '0;
      periph_cs <= 1'b0;
      phys_addr <= '0;
      abort_o   <= 1'b0;
    end else begin
      sel_vld   <= ev_pass;
      ext_cs    <= ev_pass ? dec_ext : '0;
      int_cs    <= ev_pass ? dec_int : '0;
      periph_cs <= ev_pass && dec_periph;
      phys_addr <= ev_pass ? dec_phys : '0;
      abort_o   <= ev_fire;
    end
  end

  brd_abort_capture #(
    .MASTER_W (MASTER_W)
  ) u_abt (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (ev_fire),
    .cause     (ev_cause),
    .master    (req_master),
    .write     (req_write),
    .size      (req_size),
    .addr      (req_addr),
    .st_type   (abt_type),
    .st_master (abt_master),
    .st_write  (abt_write),
    .st_size   (abt_size),
    .st_addr   (abt_addr)
  );

endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int N_EXT = 8,
  parameter int N_INT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             remap_cmd,
  input logic             req_vld,
  input logic [31:0]      req_addr,
  input logic [1:0]       req_size,
  input logic             req_data,
  input logic             boot_q,
  input logic             remap_q,
  input logic             dec_undef,
  input logic             sel_vld,
  input logic [N_EXT-1:0] ext_cs,
  input logic [N_INT-1:0] int_cs,
  input logic             periph_cs,
  input logic             abort_o,
  input logic [1:0]       abt_type,
  input logic [31:0]      abt_addr
);

  a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_cs, int_cs, periph_cs}));

  a_r10_valid_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld == (|{ext_cs, int_cs, periph_cs}));

  a_r2_window_index_unused: assert property (@(posedge clk) disable iff (!rst_n)
    !int_cs[0]);

  a_r4_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_q));

  a_r5_remap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    remap_cmd |=> (remap_q != $past(remap_q)));

  a_r5_remap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_cmd |=> $stable(remap_q));

  a_r7_word_misalign_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_data && req_size[1] && (req_addr[1:0] != 2'b00)) |=> abort_o);

  a_r7_byte_never_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_size == 2'd0) && !dec_undef) |=> !abort_o);

  a_r8_undef_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && dec_undef) |=> (abort_o && abt_type == 2'd2));

  a_r9_abort_excludes_select: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!sel_vld && abt_type != 2'd0));

  a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_o |-> $stable(abt_addr));

endmodule

bind bus_remap_decoder brd_checker #(
  .N_EXT (N_EXT),
  .N_INT (N_INT)
) u_brd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .remap_cmd (remap_cmd),
  .req_vld   (req_vld),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_data  (req_data),
  .boot_q    (boot_q),
  .remap_q   (remap_q),
  .dec_undef (dec_undef),
  .sel_vld   (sel_vld),
  .ext_cs    (ext_cs),
  .int_cs    (int_cs),
  .periph_cs (periph_cs),
  .abort_o   (abort_o),
  .abt_type  (abt_type),
  .abt_addr  (abt_addr)
);

// File: tb/bus_remap_decoder_tb_top.sv
module bus_remap_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_mode_pin = 1'b1;
  logic        remap_cmd = 1'b0;
  logic        req_vld = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_data = 1'b0;
  logic [1:0]  req_master = '0;
  logic        sel_vld;
  logic [7:0]  ext_cs;
  logic [3:0]  int_cs;
  logic        periph_cs;
  logic [31:0] phys_addr;
  logic        abort_o;
  logic [1:0]  abt_type;
  logic [1:0]  abt_master;
  logic        abt_write;
  logic [1:0]  abt_size;
  logic [31:0] abt_addr;

  always #4 clk = ~clk;

  bus_remap_decoder dut_i (
    .clk (clk), .rst_n (rst_n), .boot_mode_pin (boot_mode_pin),
    .remap_cmd (remap_cmd), .req_vld (req_vld), .req_addr (req_addr),
    .req_size (req_size), .req_write (req_write), .req_data (req_data),
    .req_master (req_master), .sel_vld (sel_vld), .ext_cs (ext_cs),
    .int_cs (int_cs), .periph_cs (periph_cs), .phys_addr (phys_addr),
    .abort_o (abort_o), .abt_type (abt_type), .abt_master (abt_master),
    .abt_write (abt_write), .abt_size (abt_size), .abt_addr (abt_addr)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R10";

  // reference model state
  bit          m_boot;
  bit          m_remap;
  bit          x_sel, x_per, x_abt, x_wr;
  bit [7:0]    x_ext;
  bit [3:0]    x_int;
  bit [31:0]   x_phys, x_aaddr;
  bit [1:0]    x_atype, x_amst, x_asz;

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int unsigned nib;
    int unsigned area;
    bit          undef, mis;
    bit [7:0]    e_ext;
    bit [3:0]    e_int;
    bit          e_per;
    bit [31:0]   e_phys;
    if (!rst_n) begin
      m_boot = boot_mode_pin; m_remap = 0;
      x_sel = 0; x_ext = 0; x_int = 0; x_per = 0; x_phys = 0; x_abt = 0;
      x_atype = 0; x_amst = 0; x_wr = 0; x_asz = 0; x_aaddr = 0;
      return;
    end
    nib = req_addr[31:28]; area = req_addr[21:20];
    e_ext = 0; e_int = 0; e_per = 0; e_phys = req_addr; undef = 0;
    if (nib >= 1 && nib <= 8) e_ext[nib-1] = 1;                  // R1
    else if (nib == 15) e_per = 1;                               // R3
    else if (nib == 0) begin
      if (req_addr[27:22] != 0) undef = 1;                       // R8
      else if (area != 0) e_int[area] = 1;                       // R2
      else if (m_remap) begin e_int[2] = 1; e_phys = 32'h0020_0000 + req_addr[19:0]; end  // R5
      else if (m_boot)  begin e_int[1] = 1; e_phys = 32'h0010_0000 + req_addr[19:0]; end  // R4
      else              begin e_ext[0] = 1; e_phys = 32'h1000_0000 + req_addr[19:0]; end
    end else undef = 1;
    mis = req_data && ((req_size == 1 && req_addr[0]) || (req_size >= 2 && req_addr[1:0] != 0));  // R7
    if (req_vld && (undef || mis)) begin                         // R9
      x_abt = 1; x_sel = 0; x_ext = 0; x_int = 0; x_per = 0; x_phys = 0;
      x_atype = undef ? 2 : 1; x_amst = req_master; x_wr = req_write;
      x_asz = req_size; x_aaddr = req_addr;
    end else if (req_vld) begin
      x_abt = 0; x_sel = 1; x_ext = e_ext; x_int = e_int; x_per = e_per; x_phys = e_phys;
    end else begin                                               // R10
      x_abt = 0; x_sel = 0; x_ext = 0; x_int = 0; x_per = 0; x_phys = 0;
    end
    if (remap_cmd) m_remap = !m_remap;                           // R6: toggle after decode
  endtask

  task automatic compare_all();
    cmp("sel_vld", 32'(sel_vld), 32'(x_sel));
    cmp("ext_cs", 32'(ext_cs), 32'(x_ext));
    cmp("int_cs", 32'(int_cs), 32'(x_int));
    cmp("periph_cs", 32'(periph_cs), 32'(x_per));
    cmp("phys_addr", phys_addr, x_phys);
    cmp("abort_o", 32'(abort_o), 32'(x_abt));
    cmp("abt_type", 32'(abt_type), 32'(x_atype));
    cmp("abt_master", 32'(abt_master), 32'(x_amst));
    cmp("abt_write", 32'(abt_write), 32'(x_wr));
    cmp("abt_size", 32'(abt_size), 32'(x_asz));
    cmp("abt_addr", abt_addr, x_aaddr);
  endtask

  // called at a falling edge: drive, wait a rising edge, model, check at next falling edge
  task automatic step(input bit rq, input logic [31:0] a, input logic [1:0] sz,
                      input bit dt, input bit wr, input logic [1:0] m, input bit rc);
    req_vld = rq; req_addr = a; req_size = sz; req_data = dt;
    req_write = wr; req_master = m; remap_cmd = rc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 32'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(input bit pin);
    rst_n = 0; boot_mode_pin = pin;
    repeat (3) step(0, 32'h0, 0, 0, 0, 0, 0);
    boot_mode_pin = !pin;   // R4: pin changes after reset must be ignored
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    tag = "R9_reset"; do_reset(1);

    tag = "R1";
    for (int n = 1; n <= 8; n++) step(1, {4'(n), 28'h0ABC_DE4}, 2, 1, 0, 1, 0);
    tag = "R2";
    for (int k = 1; k < 4; k++) step(1, 32'h0000_1230 | (32'(k) << 20), 2, 1, 1, 2, 0);
    tag = "R3"; step(1, 32'hF00F_FFF0, 2, 1, 0, 0, 0);
    tag = "R4"; step(1, 32'h0000_4568, 2, 1, 0, 0, 0);
    tag = "R10"; idle();
    tag = "R7"; step(1, 32'h1000_0001, 1, 1, 1, 3, 0);
    step(1, 32'h2000_0002, 2, 1, 0, 1, 0);
    step(1, 32'h3000_0003, 3, 1, 0, 2, 0);
    step(1, 32'h4000_0003, 0, 1, 1, 0, 0);
    step(1, 32'h0010_0002, 1, 1, 0, 0, 0);
    step(1, 32'h5000_0001, 2, 0, 0, 0, 0);
    tag = "R9"; idle(); idle();
    tag = "R8"; step(1, 32'h9000_0000, 0, 1, 1, 1, 0);
    step(1, 32'hE000_0003, 2, 1, 0, 2, 0);
    step(1, 32'h0040_0000, 0, 0, 0, 3, 0);
    tag = "R5"; step(0, 32'h0, 0, 0, 0, 0, 1);
    step(1, 32'h0000_0010, 2, 1, 0, 0, 0);
    tag = "R6"; step(1, 32'h0000_0020, 2, 1, 0, 0, 1);
    step(1, 32'h0000_0024, 2, 1, 0, 0, 1);
    step(1, 32'h0000_0028, 2, 1, 0, 0, 0);

    tag = "R4"; do_reset(0);
    step(1, 32'h000F_FFFC, 2, 1, 0, 1, 0);
    tag = "R5"; step(1, 32'h0000_0100, 0, 1, 0, 1, 1);
    step(1, 32'h0000_0100, 0, 1, 0, 1, 0);
    tag = "R5_reset_clears"; do_reset(0);
    step(1, 32'h0000_0200, 0, 1, 0, 1, 0);

    tag = "R6_random";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom;
      case ($urandom_range(0, 3))
        0: a[31:20] = 12'h000;
        1: a[31:28] = 4'h0;
        default: ;
      endcase
      step($urandom_range(0, 5) != 0, a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom_range(0, 6) == 0);
      if (i == 300) begin tag = "R4_random"; do_reset(1); end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule